// File: doc/BRIEF.md
# SDIO Card Function Control Register File

This block is the control and status register file of an SDIO card function. A simple word-addressed register bus is decoded at fixed offsets. It has an address, a write enable with write data, and a read enable with registered read data. The block holds fixed version fields, capability bits, the function enable, the block sizes of function 0 and function 1, the high-speed enable, the asynchronous-interrupt enable, the busy override, the operation-conditions field, the command-error bitmap and the two transaction status nibbles.

The side-band outputs carry the programmed settings to the protocol engine. These are the function enable, the high-speed enable, the asynchronous-interrupt enable, the bus width, both block sizes and the resolved busy signal. Two outputs are one-cycle action pulses: one aborts a transaction and carries the selected function number, and the other requests a card reset. The engine returns its internal busy state, a command-done strobe with an error vector, and a status-update strobe with write and read transaction status. Read data appears in the cycle after the read enable is sampled.

The register map uses byte addresses and decodes word offsets: 0x00 identity, 0x04 bus control, 0x08 function-0 block size, 0x0C function-1 block size, 0x10 speed, 0x14 asynchronous interrupt, 0x18 busy control, 0x1C command errors, 0x20 operation conditions and 0x24 transaction status.

Top module: `sdcr_regfile`

## Requirements
- R1: After reset these registers read as follows: identity 0x00000343, speed 0x00000002, asynchronous interrupt 0x00000001, operation conditions 0x00FFFFC0, and 0 for busy control, both block sizes, command errors and transaction status. Read data for a read enable sampled at one clock edge is valid from that edge until the next one.
- R2: The identity register (0x00) carries the fixed version nibbles 3 in bits 3:0, 4 in bits 7:4 and 3 in bits 11:8, and writes do not change them. Bit 16 is a read/write function enable that drives fn_enable.
- R3: The block size registers (0x08 for function 0, 0x0C for function 1) store bits 11:0 of the write data and read 0 above bit 11. The value 0x800 (2048) is stored and appears on f0_blk_size or f1_blk_size.
- R4: In the speed register (0x10), bit 0 is the read/write high-speed enable that drives hs_enable. Bit 1 always reads 1.
- R5: In the asynchronous-interrupt register (0x14), bit 0 is the read-only support bit and equals parameter ASYNC_SUPPORT (default 1). Bit 1 is the enable that drives async_int_en. When support is 0, writes to the enable are ignored and it reads 0.
- R6: busy_out is registered. It equals the programmed busy value (0x18 bit 0) when the override bit (0x18 bit 1) is 1. Otherwise it follows busy_in. Both bits reset to 0.
- R7: A write to bus control (0x04) with a nonzero abort field in bits 6:4 raises abort_pulse for exactly the next cycle, with abort_fn carrying the field. A write with bit 8 set raises reset_pulse for exactly the next cycle. Both fields read back as 0. Bits 1:0 are the read/write bus width on bus_width.
- R8: When cmd_done is high, the command-error register (0x1C) captures cmd_err into bits 21:16. The bit order is address (16), function number (17), general (18), illegal command (19), CRC (20) and out of range (21). Without cmd_done the register holds its value.
- R9: The operation-conditions register (0x20) stores bits 23:0 of the write data and reads 0 in bits 31:24.
- R10: When xfer_upd is high, the transaction status register (0x24) captures xfer_wr_st into bits 3:0 and xfer_rd_st into bits 7:4. A read of the register returns the current value and clears both fields to 0.
- R11: Reads of unlisted offsets (for example 0x28 and 0x3C) return 0. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Byte address, word aligned |
| wr_en | input | 1 | Write strobe |
| wdata | input | DATA_W | Write data |
| rd_en | input | 1 | Read strobe |
| rdata | output | DATA_W | Registered read data |
| busy_in | input | 1 | Internal busy from the protocol engine |
| cmd_done | input | 1 | Command completion strobe |
| cmd_err | input | ERR_W | Command error vector |
| xfer_upd | input | 1 | Transaction status update strobe |
| xfer_wr_st | input | XST_W | Write transaction status |
| xfer_rd_st | input | XST_W | Read transaction status |
| fn_enable | output | 1 | Function enable |
| hs_enable | output | 1 | High-speed enable |
| async_int_en | output | 1 | Asynchronous interrupt enable |
| bus_width | output | 2 | Bus width code |
| f0_blk_size | output | BLK_W | Function-0 block size |
| f1_blk_size | output | BLK_W | Function-1 block size |
| busy_out | output | 1 | Resolved busy |
| abort_pulse | output | 1 | One-cycle abort request |
| abort_fn | output | 3 | Function selected by the abort |
| reset_pulse | output | 1 | One-cycle card reset request |

## Verification
The ignored enable write cannot be reached through a single instance with the default parameters, because the support bit is then fixed at 1. The bench therefore places a second instance with ASYNC_SUPPORT set to 0 on the same bus. It checks that this instance's enable output and read data stay 0 while the main instance accepts the same write. Clear-on-read also needs two reads in a row after a status update, so that the first read returns the captured nibbles and the second read shows the cleared value. The override case sets busy_in opposite to the programmed value, so the outputs of the two mux inputs can be told apart.

// File: rtl/sdcr_pkg.sv
package sdcr_pkg;
  localparam int REG_ID     = 0;
  localparam int REG_BUSCTL = 1;
  localparam int REG_F0BLK  = 2;
  localparam int REG_F1BLK  = 3;
  localparam int REG_SPEED  = 4;
  localparam int REG_ASYNC  = 5;
  localparam int REG_BUSY   = 6;
  localparam int REG_CMDERR = 7;
  localparam int REG_OCR    = 8;
  localparam int REG_XFER   = 9;

  localparam logic [3:0] VER_FORMAT = 4'h3;
  localparam logic [3:0] VER_SDIO   = 4'h4;
  localparam logic [3:0] VER_PHY    = 4'h3;

  localparam int ERR_LSB = 16;
endpackage

// File: rtl/sdcr_pulse_gen.sv
module sdcr_pulse_gen #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         fire,
  input  logic [W-1:0] val,
  output logic         pulse,
  output logic [W-1:0] val_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pulse <= 1'b0;
      val_q <= '0;
    end else begin
      pulse <= fire;
      val_q <= fire ? val : '0;
    end
  end

  // R7: a pulse only follows an accepted trigger
  assert_pulse_cause_R7: assert property (@(posedge clk) disable iff (rst)
    pulse |-> $past(fire));
  assert_pulse_drop_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(fire) |-> !pulse && (val_q == '0));
endmodule

// File: rtl/sdcr_status_cap.sv
module sdcr_status_cap #(
  parameter int W = 4,
  parameter bit CLR_ON_READ = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         upd,
  input  logic [W-1:0] din,
  input  logic         rd_clr,
  output logic [W-1:0] q
);
  generate
    if (CLR_ON_READ) begin : g_clr
      // an update in the same cycle as a clearing read wins
      always_ff @(posedge clk) begin
        if (rst)         q <= '0;
        else if (upd)    q <= din;
        else if (rd_clr) q <= '0;
      end
      assert_clr_on_read_R10: assert property (@(posedge clk) disable iff (rst)
        $past(rd_clr && !upd) |-> (q == '0));
    end else begin : g_hold
      always_ff @(posedge clk) begin
        if (rst)      q <= '0;
        else if (upd) q <= din;
      end
      assert_err_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !$past(upd) |-> $stable(q));
    end
  endgenerate

  assert_capture_R8: assert property (@(posedge clk) disable iff (rst)
    upd |=> (q == $past(din)));
endmodule

// File: rtl/sdcr_busy_mux.sv
module sdcr_busy_mux (
  input  logic clk,
  input  logic rst,
  input  logic ovr,
  input  logic ovr_val,
  input  logic busy_in,
  output logic busy_out
);
  always_ff @(posedge clk) begin
    if (rst) busy_out <= 1'b0;
    else     busy_out <= ovr ? ovr_val : busy_in;
  end

  assert_busy_follow_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(ovr) |-> (busy_out == $past(busy_in)));
  assert_busy_forced_R6: assert property (@(posedge clk) disable iff (rst)
    $past(ovr) |-> (busy_out == $past(ovr_val)));
endmodule

// File: rtl/sdcr_regfile.sv
module sdcr_regfile
  import sdcr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int BLK_W  = 12,
  parameter int OCR_W  = 24,
  parameter logic [OCR_W-1:0] OCR_RST = 24'hFFFFC0,
  parameter bit ASYNC_SUPPORT = 1'b1,
  parameter int ERR_W  = 6,
  parameter int XST_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rdata,
  input  logic              busy_in,
  input  logic              cmd_done,
  input  logic [ERR_W-1:0]  cmd_err,
  input  logic              xfer_upd,
  input  logic [XST_W-1:0]  xfer_wr_st,
  input  logic [XST_W-1:0]  xfer_rd_st,
  output logic              fn_enable,
  output logic              hs_enable,
  output logic              async_int_en,
  output logic [1:0]        bus_width,
  output logic [BLK_W-1:0]  f0_blk_size,
  output logic [BLK_W-1:0]  f1_blk_size,
  output logic              busy_out,
  output logic              abort_pulse,
  output logic [2:0]        abort_fn,
  output logic              reset_pulse
);
  localparam int WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0] widx;
  assign widx = addr[ADDR_W-1:2];

  logic sel_id, sel_bus, sel_f0, sel_f1, sel_spd, sel_async, sel_busy, sel_ocr, sel_xfer;
  assign sel_id    = (widx == WIDX_W'(REG_ID));
  assign sel_bus   = (widx == WIDX_W'(REG_BUSCTL));
  assign sel_f0    = (widx == WIDX_W'(REG_F0BLK));
  assign sel_f1    = (widx == WIDX_W'(REG_F1BLK));
  assign sel_spd   = (widx == WIDX_W'(REG_SPEED));
  assign sel_async = (widx == WIDX_W'(REG_ASYNC));
  assign sel_busy  = (widx == WIDX_W'(REG_BUSY));
  assign sel_ocr   = (widx == WIDX_W'(REG_OCR));
  assign sel_xfer  = (widx == WIDX_W'(REG_XFER));

  logic             fn_en_q, hs_en_q, async_q, busy_ov_q, busy_val_q;
  logic [1:0]       bw_q;
  logic [BLK_W-1:0] f0_q, f1_q;
  logic [OCR_W-1:0] ocr_q;
  logic [ERR_W-1:0] err_q;
  logic [XST_W-1:0] xwr_q, xrd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fn_en_q    <= 1'b0;
      hs_en_q    <= 1'b0;
      busy_ov_q  <= 1'b0;
      busy_val_q <= 1'b0;
      bw_q       <= '0;
      f0_q       <= '0;
      f1_q       <= '0;
      ocr_q      <= OCR_RST;
    end else if (wr_en) begin
      if (sel_id)   fn_en_q <= wdata[16];
      if (sel_bus)  bw_q    <= wdata[1:0];
      if (sel_f0)   f0_q    <= wdata[BLK_W-1:0];
      if (sel_f1)   f1_q    <= wdata[BLK_W-1:0];
      if (sel_spd)  hs_en_q <= wdata[0];
      if (sel_ocr)  ocr_q   <= wdata[OCR_W-1:0];
      if (sel_busy) begin
        busy_val_q <= wdata[0];
        busy_ov_q  <= wdata[1];
      end
    end
  end

  generate
    if (ASYNC_SUPPORT) begin : g_async
      always_ff @(posedge clk) begin
        if (rst)                       async_q <= 1'b0;
        else if (wr_en && sel_async)   async_q <= wdata[1];
      end
    end else begin : g_noasync
      assign async_q = 1'b0;
    end
  endgenerate

  sdcr_pulse_gen #(.W(3)) u_abort (
    .clk(clk), .rst(rst),
    .fire(wr_en && sel_bus && (wdata[6:4] != 3'd0)),
    .val(wdata[6:4]), .pulse(abort_pulse), .val_q(abort_fn));

  logic rst_fn_unused;
  sdcr_pulse_gen #(.W(1)) u_cardrst (
    .clk(clk), .rst(rst),
    .fire(wr_en && sel_bus && wdata[8]),
    .val(1'b1), .pulse(reset_pulse), .val_q(rst_fn_unused));

  sdcr_status_cap #(.W(ERR_W), .CLR_ON_READ(1'b0)) u_cmderr (
    .clk(clk), .rst(rst), .upd(cmd_done), .din(cmd_err), .rd_clr(1'b0), .q(err_q));

  logic xfer_clr;
  assign xfer_clr = rd_en && sel_xfer;

  sdcr_status_cap #(.W(XST_W), .CLR_ON_READ(1'b1)) u_xwr (
    .clk(clk), .rst(rst), .upd(xfer_upd), .din(xfer_wr_st), .rd_clr(xfer_clr), .q(xwr_q));
  sdcr_status_cap #(.W(XST_W), .CLR_ON_READ(1'b1)) u_xrd (
    .clk(clk), .rst(rst), .upd(xfer_upd), .din(xfer_rd_st), .rd_clr(xfer_clr), .q(xrd_q));

  sdcr_busy_mux u_busy (
    .clk(clk), .rst(rst), .ovr(busy_ov_q), .ovr_val(busy_val_q),
    .busy_in(busy_in), .busy_out(busy_out));

  logic [DATA_W-1:0] rd_mux;
  logic              map_hit;

  always_comb begin
    rd_mux  = '0;
    map_hit = 1'b1;
    case (widx)
      WIDX_W'(REG_ID): begin
        rd_mux[3:0]  = VER_FORMAT;
        rd_mux[7:4]  = VER_SDIO;
        rd_mux[11:8] = VER_PHY;
        rd_mux[16]   = fn_en_q;
      end
      WIDX_W'(REG_BUSCTL): rd_mux[1:0] = bw_q;
      WIDX_W'(REG_F0BLK):  rd_mux[BLK_W-1:0] = f0_q;
      WIDX_W'(REG_F1BLK):  rd_mux[BLK_W-1:0] = f1_q;
      WIDX_W'(REG_SPEED): begin
        rd_mux[0] = hs_en_q;
        rd_mux[1] = 1'b1;
      end
      WIDX_W'(REG_ASYNC): begin
        rd_mux[0] = ASYNC_SUPPORT;
        rd_mux[1] = async_q;
      end
      WIDX_W'(REG_BUSY): begin
        rd_mux[0] = busy_val_q;
        rd_mux[1] = busy_ov_q;
      end
      WIDX_W'(REG_CMDERR): rd_mux[ERR_LSB +: ERR_W] = err_q;
      WIDX_W'(REG_OCR):    rd_mux[OCR_W-1:0] = ocr_q;
      WIDX_W'(REG_XFER): begin
        rd_mux[XST_W-1:0]       = xwr_q;
        rd_mux[2*XST_W-1:XST_W] = xrd_q;
      end
      default: map_hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  assign fn_enable    = fn_en_q;
  assign hs_enable    = hs_en_q;
  assign async_int_en = async_q;
  assign bus_width    = bw_q;
  assign f0_blk_size  = f0_q;
  assign f1_blk_size  = f1_q;

  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (rst)
    $past(rd_en && !map_hit) |-> (rdata == '0));
  assert_async_gate_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(async_int_en) |-> $past(wr_en && sel_async && wdata[1]));
  assert_rdata_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_en) |-> $stable(rdata));
endmodule

// File: tb/test_sdcr_regfile.sv
module test_sdcr_regfile;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rdata, rdata_ns;
  logic        busy_in = 1'b0;
  logic        cmd_done = 1'b0;
  logic [5:0]  cmd_err = '0;
  logic        xfer_upd = 1'b0;
  logic [3:0]  xfer_wr_st = '0, xfer_rd_st = '0;
  logic        fn_enable, hs_enable, async_int_en, busy_out, abort_pulse, reset_pulse;
  logic [1:0]  bus_width;
  logic [11:0] f0_blk_size, f1_blk_size;
  logic [2:0]  abort_fn;
  logic        ns_fn, ns_hs, ns_async, ns_busy, ns_abort, ns_rst;
  logic [1:0]  ns_bw;
  logic [11:0] ns_f0, ns_f1;
  logic [2:0]  ns_afn;

  always #5 clk = ~clk;

  sdcr_regfile i_sdcr_regfile (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata), .rd_en(rd_en),
    .rdata(rdata), .busy_in(busy_in), .cmd_done(cmd_done), .cmd_err(cmd_err),
    .xfer_upd(xfer_upd), .xfer_wr_st(xfer_wr_st), .xfer_rd_st(xfer_rd_st),
    .fn_enable(fn_enable), .hs_enable(hs_enable), .async_int_en(async_int_en),
    .bus_width(bus_width), .f0_blk_size(f0_blk_size), .f1_blk_size(f1_blk_size),
    .busy_out(busy_out), .abort_pulse(abort_pulse), .abort_fn(abort_fn),
    .reset_pulse(reset_pulse));

  sdcr_regfile #(.ASYNC_SUPPORT(1'b0)) i_sdcr_regfile_nosup (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata), .rd_en(rd_en),
    .rdata(rdata_ns), .busy_in(busy_in), .cmd_done(cmd_done), .cmd_err(cmd_err),
    .xfer_upd(xfer_upd), .xfer_wr_st(xfer_wr_st), .xfer_rd_st(xfer_rd_st),
    .fn_enable(ns_fn), .hs_enable(ns_hs), .async_int_en(ns_async),
    .bus_width(ns_bw), .f0_blk_size(ns_f0), .f1_blk_size(ns_f1),
    .busy_out(ns_busy), .abort_pulse(ns_abort), .abort_fn(ns_afn),
    .reset_pulse(ns_rst));

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  always @(posedge clk) rd_seen <= rd_en;

  // monitor: compares each read result against the scoreboard queue
  always @(negedge clk) begin
    if (rd_seen && !rst && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_cmp++;
      if (rdata !== e) begin
        n_bad++;
        $display("FAIL %s: rdata actual %h expected %h", t, rdata, e);
      end
    end
  end

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(posedge clk); #1;
    addr = a; rd_en = 1'b1;
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state
    rd(8'h00, 32'h0000_0343, "R1 identity");
    rd(8'h10, 32'h0000_0002, "R1 speed");
    rd(8'h14, 32'h0000_0001, "R1 async");
    rd(8'h20, 32'h00FF_FFC0, "R1 ocr");
    rd(8'h08, 32'h0, "R1 f0 blk");
    rd(8'h18, 32'h0, "R1 busy ctl");
    rd(8'h24, 32'h0, "R1 xfer");
    chk("R1 fn_enable", {31'd0, fn_enable}, 32'd0);

    // R2 version read-only, function enable
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, 32'h0001_0343, "R2 identity after write");
    chk("R2 fn_enable", {31'd0, fn_enable}, 32'd1);
    wr(8'h00, 32'h0000_0000);
    chk("R2 fn_enable off", {31'd0, fn_enable}, 32'd0);

    // R3 block sizes
    wr(8'h08, 32'hFFFF_F800);
    rd(8'h08, 32'h0000_0800, "R3 f0 blk 2048");
    chk("R3 f0 output", {20'd0, f0_blk_size}, 32'h800);
    wr(8'h0C, 32'h0000_0ABC);
    rd(8'h0C, 32'h0000_0ABC, "R3 f1 blk");
    chk("R3 f1 output", {20'd0, f1_blk_size}, 32'hABC);

    // R4 high speed
    wr(8'h10, 32'hFFFF_FFFD);
    rd(8'h10, 32'h0000_0003, "R4 speed");
    chk("R4 hs_enable", {31'd0, hs_enable}, 32'd1);

    // R5 asynchronous interrupt, supported and unsupported instances
    wr(8'h14, 32'h0000_0002);
    chk("R5 async_int_en", {31'd0, async_int_en}, 32'd1);
    chk("R5 nosup async_int_en", {31'd0, ns_async}, 32'd0);
    rd(8'h14, 32'h0000_0003, "R5 async readback");
    chk("R5 nosup readback", rdata_ns, 32'd0);

    // R6 busy mux
    busy_in = 1'b1;
    @(posedge clk); #1;
    chk("R6 follow busy_in", {31'd0, busy_out}, 32'd1);
    wr(8'h18, 32'h0000_0002);
    @(posedge clk); #1;
    chk("R6 override low", {31'd0, busy_out}, 32'd0);
    busy_in = 1'b0;
    wr(8'h18, 32'h0000_0003);
    @(posedge clk); #1;
    chk("R6 override high", {31'd0, busy_out}, 32'd1);
    wr(8'h18, 32'h0000_0001);
    @(posedge clk); #1;
    chk("R6 override released", {31'd0, busy_out}, 32'd0);

    // R7 abort and reset pulses
    wr(8'h04, 32'h0000_0153);
    chk("R7 abort pulse", {31'd0, abort_pulse}, 32'd1);
    chk("R7 abort fn", {29'd0, abort_fn}, 32'd5);
    chk("R7 reset pulse", {31'd0, reset_pulse}, 32'd1);
    @(posedge clk); #1;
    chk("R7 abort one cycle", {31'd0, abort_pulse}, 32'd0);
    chk("R7 reset one cycle", {31'd0, reset_pulse}, 32'd0);
    rd(8'h04, 32'h0000_0003, "R7 bus ctl readback");
    chk("R7 bus width", {30'd0, bus_width}, 32'd3);
    wr(8'h04, 32'h0000_0001);
    chk("R7 no abort on zero field", {31'd0, abort_pulse}, 32'd0);

    // R8 command errors
    @(posedge clk); #1;
    cmd_err = 6'b100101; cmd_done = 1'b1;
    @(posedge clk); #1;
    cmd_done = 1'b0; cmd_err = 6'b011010;
    rd(8'h1C, 32'h0025_0000, "R8 captured bitmap");
    rd(8'h1C, 32'h0025_0000, "R8 hold without done");

    // R9 operation conditions
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20, 32'h00FF_FFFF, "R9 ocr all ones");
    wr(8'h20, 32'h1234_5678);
    rd(8'h20, 32'h0034_5678, "R9 ocr pattern");

    // R10 transaction status clear on read
    @(posedge clk); #1;
    xfer_wr_st = 4'hA; xfer_rd_st = 4'h5; xfer_upd = 1'b1;
    @(posedge clk); #1;
    xfer_upd = 1'b0;
    rd(8'h24, 32'h0000_005A, "R10 status captured");
    rd(8'h24, 32'h0000_0000, "R10 status cleared");

    // R11 unlisted offsets
    wr(8'h28, 32'hFFFF_FFFF);
    rd(8'h28, 32'h0, "R11 unmapped 0x28");
    rd(8'h3C, 32'h0, "R11 unmapped 0x3C");
    rd(8'h20, 32'h0034_5678, "R11 ocr untouched");
    rd(8'h0C, 32'h0000_0ABC, "R11 f1 untouched");

    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule